// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block produces one interrupt line for each side of a two-port shared memory. It listens to the address and control signals each port presents to the memory array and uses two reserved words at the very top of the address space as doorbells. When one side writes the doorbell word that belongs to the other side, the other side's interrupt goes active. When a side reads its own doorbell word, its own interrupt is released. The mailbox contents live in the memory array, and this block stores nothing but the two flags.

The side labelled left owns the word one below the highest address, and the side labelled right owns the highest address. Each side therefore rings the other by writing the other's word and acknowledges by reading its own. An access counts only when it is a plain memory access: chip enable active and semaphore select inactive. A read also needs output enable. All control inputs are active low. The read/write input is high for a read and low for a write. The flags change on the clock edge that samples the access. Both interrupt outputs are active low and always driven.

Top module: `mbox_intr`

## Requirements
- R1: While reset is held and on the first cycle after its release, both interrupt outputs are high.
- R2: A right-port write (rCeN=0, rSemN=1, rRwN=0) to address 2^ADDR_W-2 (1FFE hex at the default width) drives lIntN low after the next clock edge.
- R3: A left-port read (lCeN=0, lSemN=1, lRwN=1, lOeN=0) of address 2^ADDR_W-2 drives lIntN high after the next clock edge, unless R8 applies.
- R4: A left-port write to address 2^ADDR_W-1 (1FFF hex at the default width) drives rIntN low after the next clock edge.
- R5: A right-port read of address 2^ADDR_W-1 drives rIntN high after the next clock edge, unless R8 applies.
- R6: An access made with that port's semaphore select low (semN=0) neither sets nor clears any interrupt.
- R7: An access made with chip enable high has no effect, and a read made with output enable high does not clear an interrupt.
- R8: When a set and a clear of the same interrupt occur on the same edge, the interrupt ends up active (low).
- R9: Accesses to any other address, a port writing its own mailbox word, and a port reading the other port's mailbox word leave both interrupt outputs unchanged.
- R10: The two interrupts are independent: both may be set on one edge, and setting or clearing one leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock on which accesses are sampled |
| rstN | input | 1 | Asynchronous reset, active low |
| lAddr | input | ADDR_W | Left port address |
| lCeN | input | 1 | Left chip enable, active low |
| lRwN | input | 1 | Left direction, 1 read, 0 write |
| lOeN | input | 1 | Left output enable, active low |
| lSemN | input | 1 | Left semaphore select, active low; high means memory access |
| rAddr | input | ADDR_W | Right port address |
| rCeN | input | 1 | Right chip enable, active low |
| rRwN | input | 1 | Right direction, 1 read, 0 write |
| rOeN | input | 1 | Right output enable, active low |
| rSemN | input | 1 | Right semaphore select, active low; high means memory access |
| lIntN | output | 1 | Interrupt to the left side, active low, push-pull |
| rIntN | output | 1 | Interrupt to the right side, active low, push-pull |

## Verification
The bench builds the block with ADDR_W set to 4, so the two mailbox words sit at addresses 14 and 15. Their neighbour 13 and the wrap-around address 0 can then be reached with short literal addresses, and the exact-match decode is probed on every side of both doorbells. Each side's qualifier is disabled in turn: semaphore select, chip enable and output enable. The cases where a set and a clear land together, and where both flags are set on one edge, are driven directly.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Strobes from the access decoder to the flag datapath.
  typedef struct packed {
    logic setLeft;
    logic clrLeft;
    logic setRight;
    logic clrRight;
  } mboxStrobes_t;

  localparam int NUM_SIDES = 2;
  localparam int SIDE_LEFT = 0;
  localparam int SIDE_RIGHT = 1;

endpackage

// File: rtl/mbox_port_dec.sv
module mbox_port_dec #(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] OWN_BOX = '1,
  parameter logic [ADDR_W-1:0] PEER_BOX = '0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              ceN,
  input  logic              rwN,
  input  logic              oeN,
  input  logic              semN,
  output logic              ringPeer,
  output logic              ackOwn
);

  logic memAccess;
  logic isWrite;
  logic isRead;

  always_comb begin
    memAccess = !ceN && semN;
    isWrite   = memAccess && !rwN;
    isRead    = memAccess && rwN && !oeN;
    ringPeer  = isWrite && (addr == PEER_BOX);
    ackOwn    = isRead && (addr == OWN_BOX);
  end

endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic [NUM_SIDES-1:0][ADDR_W-1:0] addrs,
  input  logic [NUM_SIDES-1:0]             ceNs,
  input  logic [NUM_SIDES-1:0]             rwNs,
  input  logic [NUM_SIDES-1:0]             oeNs,
  input  logic [NUM_SIDES-1:0]             semNs,
  output mboxStrobes_t                     strobes
);

  localparam logic [ADDR_W-1:0] BOX_RIGHT = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] BOX_LEFT  = {{(ADDR_W-1){1'b1}}, 1'b0};

  logic [NUM_SIDES-1:0] ringPeer;
  logic [NUM_SIDES-1:0] ackOwn;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    localparam logic [ADDR_W-1:0] OWN  = (s == SIDE_LEFT) ? BOX_LEFT : BOX_RIGHT;
    localparam logic [ADDR_W-1:0] PEER = (s == SIDE_LEFT) ? BOX_RIGHT : BOX_LEFT;
    mbox_port_dec #(
      .ADDR_W  (ADDR_W),
      .OWN_BOX (OWN),
      .PEER_BOX(PEER)
    ) u_dec (
      .addr    (addrs[s]),
      .ceN     (ceNs[s]),
      .rwN     (rwNs[s]),
      .oeN     (oeNs[s]),
      .semN    (semNs[s]),
      .ringPeer(ringPeer[s]),
      .ackOwn  (ackOwn[s])
    );
  end

  always_comb begin
    strobes.setLeft  = ringPeer[SIDE_RIGHT];
    strobes.clrLeft  = ackOwn[SIDE_LEFT];
    strobes.setRight = ringPeer[SIDE_LEFT];
    strobes.clrRight = ackOwn[SIDE_RIGHT];
  end

endmodule

// File: rtl/mbox_flags.sv
module mbox_flags
  import mbox_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  mboxStrobes_t strobes,
  output logic         lIntN,
  output logic         rIntN
);

  logic [NUM_SIDES-1:0] setVec;
  logic [NUM_SIDES-1:0] clrVec;
  logic [NUM_SIDES-1:0] flagQ;

  always_comb begin
    setVec[SIDE_LEFT]  = strobes.setLeft;
    setVec[SIDE_RIGHT] = strobes.setRight;
    clrVec[SIDE_LEFT]  = strobes.clrLeft;
    clrVec[SIDE_RIGHT] = strobes.clrRight;
  end

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_flag
    // set has priority over clear
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flagQ[s] <= 1'b0;
      end else if (setVec[s]) begin
        flagQ[s] <= 1'b1;
      end else if (clrVec[s]) begin
        flagQ[s] <= 1'b0;
      end
    end
  end

  assign lIntN = ~flagQ[SIDE_LEFT];
  assign rIntN = ~flagQ[SIDE_RIGHT];

endmodule

// File: rtl/mbox_intr.sv
module mbox_intr
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              lCeN,
  input  logic              lRwN,
  input  logic              lOeN,
  input  logic              lSemN,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic              rCeN,
  input  logic              rRwN,
  input  logic              rOeN,
  input  logic              rSemN,
  output logic              lIntN,
  output logic              rIntN
);

  mboxStrobes_t strobes;

  mbox_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .addrs  ({rAddr, lAddr}),
    .ceNs   ({rCeN, lCeN}),
    .rwNs   ({rRwN, lRwN}),
    .oeNs   ({rOeN, lOeN}),
    .semNs  ({rSemN, lSemN}),
    .strobes(strobes)
  );

  mbox_flags u_flags (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .lIntN  (lIntN),
    .rIntN  (rIntN)
  );

endmodule

// File: rtl/mbox_intr_chk.sv
module mbox_intr_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] lAddr,
  input logic              lCeN,
  input logic              lRwN,
  input logic              lOeN,
  input logic              lSemN,
  input logic [ADDR_W-1:0] rAddr,
  input logic              rCeN,
  input logic              rRwN,
  input logic              rOeN,
  input logic              rSemN,
  input logic              lIntN,
  input logic              rIntN
);

  localparam logic [ADDR_W-1:0] TOP_WORD  = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] NEXT_WORD = {{(ADDR_W-1){1'b1}}, 1'b0};

  logic ringL, ackL, ringR, ackR;
  assign ringL = !rCeN && rSemN && !rRwN && (rAddr == NEXT_WORD);
  assign ackL  = !lCeN && lSemN && lRwN && !lOeN && (lAddr == NEXT_WORD);
  assign ringR = !lCeN && lSemN && !lRwN && (lAddr == TOP_WORD);
  assign ackR  = !rCeN && rSemN && rRwN && !rOeN && (rAddr == TOP_WORD);

  p_reset_idle_r1: assert property (@(posedge clk) !rstN |=> (lIntN && rIntN));
  p_left_set_r2:   assert property (@(posedge clk) disable iff (!rstN) ringL |=> !lIntN);
  p_left_clr_r3:   assert property (@(posedge clk) disable iff (!rstN) (ackL && !ringL) |=> lIntN);
  p_right_set_r4:  assert property (@(posedge clk) disable iff (!rstN) ringR |=> !rIntN);
  p_right_clr_r5:  assert property (@(posedge clk) disable iff (!rstN) (ackR && !ringR) |=> rIntN);
  p_sem_blocks_r6: assert property (@(posedge clk) disable iff (!rstN)
                     (!lSemN && !rSemN) |=> ($stable(lIntN) && $stable(rIntN)));
  p_ce_blocks_r7:  assert property (@(posedge clk) disable iff (!rstN)
                     (lCeN && rCeN) |=> ($stable(lIntN) && $stable(rIntN)));
  p_set_wins_r8:   assert property (@(posedge clk) disable iff (!rstN)
                     (ringL && ackL) |=> !lIntN);
  p_hold_left_r9:  assert property (@(posedge clk) disable iff (!rstN)
                     (!ringL && !ackL) |=> $stable(lIntN));
  p_hold_right_r9: assert property (@(posedge clk) disable iff (!rstN)
                     (!ringR && !ackR) |=> $stable(rIntN));

endmodule

bind mbox_intr mbox_intr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk  (clk),
  .rstN (rstN),
  .lAddr(lAddr),
  .lCeN (lCeN),
  .lRwN (lRwN),
  .lOeN (lOeN),
  .lSemN(lSemN),
  .rAddr(rAddr),
  .rCeN (rCeN),
  .rRwN (rRwN),
  .rOeN (rOeN),
  .rSemN(rSemN),
  .lIntN(lIntN),
  .rIntN(rIntN)
);

// File: tb/mbox_intr_bench.sv
module mbox_intr_bench;

  localparam int AW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] lAddr = '0, rAddr = '0;
  logic lCeN = 1'b1, lRwN = 1'b1, lOeN = 1'b1, lSemN = 1'b1;
  logic rCeN = 1'b1, rRwN = 1'b1, rOeN = 1'b1, rSemN = 1'b1;
  logic lIntN, rIntN;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit expL = 0;  // 1 = interrupt active
  bit expR = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  mbox_intr #(.ADDR_W(AW)) u_mbox_intr (
    .clk(clk), .rstN(rstN),
    .lAddr(lAddr), .lCeN(lCeN), .lRwN(lRwN), .lOeN(lOeN), .lSemN(lSemN),
    .rAddr(rAddr), .rCeN(rCeN), .rRwN(rRwN), .rOeN(rOeN), .rSemN(rSemN),
    .lIntN(lIntN), .rIntN(rIntN)
  );

  task automatic check(string req, logic act, logic exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic idle();
    lCeN = 1; lRwN = 1; lOeN = 1; lSemN = 1; lAddr = 0;
    rCeN = 1; rRwN = 1; rOeN = 1; rSemN = 1; rAddr = 0;
  endtask

  task automatic lAcc(int a, bit wr, bit oe = 1, bit sem = 1, bit ce = 1);
    lAddr = AW'(a); lCeN = !ce; lRwN = !wr; lOeN = !oe; lSemN = sem;
  endtask

  task automatic rAcc(int a, bit wr, bit oe = 1, bit sem = 1, bit ce = 1);
    rAddr = AW'(a); rCeN = !ce; rRwN = !wr; rOeN = !oe; rSemN = sem;
  endtask

  // One clock: reference model updates on the edge, outputs compared after it.
  task automatic step(string req);
    bit lWr, lRd, rWr, rRd, nextL, nextR;
    @(posedge clk);
    lWr = (lCeN == 0) && (lSemN == 1) && (lRwN == 0);
    lRd = (lCeN == 0) && (lSemN == 1) && (lRwN == 1) && (lOeN == 0);
    rWr = (rCeN == 0) && (rSemN == 1) && (rRwN == 0);
    rRd = (rCeN == 0) && (rSemN == 1) && (rRwN == 1) && (rOeN == 0);
    nextL = expL; nextR = expR;
    if (!rstN) begin
      nextL = 0; nextR = 0;
    end else begin
      if (rWr && rAddr == 14) nextL = 1;
      else if (lRd && lAddr == 14) nextL = 0;
      if (lWr && lAddr == 15) nextR = 1;
      else if (rRd && rAddr == 15) nextR = 0;
    end
    expL = nextL; expR = nextR;
    @(negedge clk);
    check(req, lIntN, !expL, "lIntN");
    check(req, rIntN, !expR, "rIntN");
    idle();
  endtask

  initial begin
    idle();
    rstN = 0;
    step("R1"); step("R1");
    @(negedge clk); rstN = 1;
    step("R1");
    check("R1", lIntN, 1'b1, "lIntN after reset");
    check("R1", rIntN, 1'b1, "rIntN after reset");

    // R2: right rings left
    rAcc(14, 1); step("R2");
    check("R2", lIntN, 1'b0, "lIntN set");
    // R9: wrong direction / wrong owner
    rAcc(14, 0, 1); step("R9");
    lAcc(14, 1); step("R9");
    rAcc(15, 0, 1); step("R9");
    check("R9", lIntN, 1'b0, "lIntN held");
    // R3: left acknowledges
    lAcc(14, 0, 1); step("R3");
    check("R3", lIntN, 1'b1, "lIntN cleared");

    // R4 / R10: left rings right, left stays idle
    lAcc(15, 1); step("R4");
    check("R4", rIntN, 1'b0, "rIntN set");
    check("R10", lIntN, 1'b1, "lIntN untouched");
    rAcc(15, 1); step("R9");
    lAcc(15, 0, 1); step("R9");
    // R5
    rAcc(15, 0, 1); step("R5");
    check("R5", rIntN, 1'b1, "rIntN cleared");

    // R6: semaphore select blocks set and clear
    rAcc(14, 1, 0, 0); step("R6");
    lAcc(15, 1, 0, 0); step("R6");
    check("R6", lIntN, 1'b1, "lIntN no set");
    check("R6", rIntN, 1'b1, "rIntN no set");
    rAcc(14, 1); lAcc(15, 1); step("R10");
    check("R10", lIntN, 1'b0, "both set lIntN");
    check("R10", rIntN, 1'b0, "both set rIntN");
    lAcc(14, 0, 1, 0); rAcc(15, 0, 1, 0); step("R6");
    check("R6", lIntN, 1'b0, "lIntN no clear");

    // R7: chip enable and output enable qualifiers
    lAcc(14, 0, 1, 1, 0); step("R7");
    lAcc(14, 0, 0); step("R7");
    rAcc(15, 0, 0); step("R7");
    check("R7", lIntN, 1'b0, "lIntN oe off");
    check("R7", rIntN, 1'b0, "rIntN oe off");
    lAcc(14, 0, 1); step("R3");
    check("R10", rIntN, 1'b0, "rIntN kept");
    rAcc(15, 0, 1); step("R5");
    rAcc(14, 1, 0, 1, 0); lAcc(15, 1, 0, 1, 0); step("R7");
    check("R7", lIntN, 1'b1, "ce off no set");

    // R8: set beats clear
    rAcc(14, 1); lAcc(14, 0, 1); step("R8");
    check("R8", lIntN, 1'b0, "set wins from idle");
    rAcc(14, 1); lAcc(14, 0, 1); step("R8");
    check("R8", lIntN, 1'b0, "set wins when active");
    lAcc(15, 1); rAcc(15, 0, 1); step("R8");
    check("R8", rIntN, 1'b0, "right set wins");

    // R9: neighbouring and wrap-around addresses
    lAcc(14, 0, 1); rAcc(15, 0, 1); step("R3");
    rAcc(13, 1); lAcc(0, 1); step("R9");
    rAcc(0, 1); lAcc(13, 1); step("R9");
    check("R9", lIntN, 1'b1, "lIntN other addr");
    check("R9", rIntN, 1'b1, "rIntN other addr");
    rAcc(14, 1); step("R2");
    lAcc(13, 0, 1); step("R9");
    lAcc(15, 0, 1); step("R9");
    check("R9", lIntN, 1'b0, "lIntN other read");

    // reset mid-operation
    lAcc(15, 1); step("R4");
    rstN = 0; step("R1");
    rstN = 1; step("R1");
    check("R1", lIntN, 1'b1, "lIntN re-reset");
    check("R1", rIntN, 1'b1, "rIntN re-reset");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected<=5000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule